// File: doc/BRIEF.md
# Configurable Memory-Mapped GPIO Controller

This block is a general-purpose I/O peripheral on a plain word-addressed register bus. Build-time parameters decide which of five registers exist and at which word offset each one sits. The five registers are a line-level register, a bit-set register, a bit-clear register, a direction register where 1 means output, and a direction register where 1 means input. Other parameters set the register width, which is also the number of lines, whether the block may drive its lines at all, and whether bus bytes are swapped end for end.

The block keeps one output-value vector and one output-enable vector and presents both on its pins. When a register is left out, the block changes how the remaining registers behave on a write. With no clear register, the set register loads the whole output value. With no set register, the line-level register becomes writable and loads the output value. External line levels pass through a two-stage synchroniser before they can be read. A read of the line-level register returns the driven value for lines that are outputs and the synchronised pin level for lines that are inputs.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: The number of lines equals WIDTH, and bit i of every register belongs to line i (bit 0 is line 0).
- R2: After reset every line is an input (`gpio_oe` = 0) with output value 0. The output-direction register reads all zeros and the input-direction register reads all ones.
- R3: For an input line, a level change on `gpio_in` is first seen in a line-level read after the second rising clock edge. For an output line, that read returns the driven output value.
- R4: With the clear register present, writing the set register drives high every line whose bit is 1 and leaves every line whose bit is 0 unchanged.
- R5: Writing the clear register drives low every line whose bit is 1 and leaves every line whose bit is 0 unchanged.
- R6: With the clear register absent, writing the set register loads the whole output value, so 0 bits drive their lines low.
- R7: With the set register absent, writing the line-level register loads the output value. With the set register present, writes to the line-level register are ignored.
- R8: Writing the output-direction register makes a line an output where its bit is 1 and an input where its bit is 0. Reading it returns `gpio_oe`.
- R9: The input-direction register has the inverse polarity: a 1 makes a line an input. Reading it returns the inverse of `gpio_oe`. When both direction registers exist, they share one direction state.
- R10: With NO_OUTPUT set, `gpio_oe` and `gpio_out` stay 0 whatever is written, and line-level reads return the synchronised pins.
- R11: With BIG_ENDIAN set, bus byte k maps to register byte NB-1-k (NB = WIDTH/8) on both writes and reads. With BIG_ENDIAN clear, the mapping is the identity.
- R12: A read of an offset that holds no present register returns 0, and a write to such an offset changes nothing.
- R13: Reading the set register or the clear register returns the current output value.
- R14: Output value and direction change only on a write to a present register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | WIDTH | Write data in bus byte order |
| bus_rdata | output | WIDTH | Read data in bus byte order (combinational, 0 when not reading) |
| gpio_in | input | WIDTH | External line levels (asynchronous) |
| gpio_out | output | WIDTH | Driven value per line |
| gpio_oe | output | WIDTH | Output enable per line |

## Verification
On every cycle, the assertions check the write rules of the output state. Set writes raise only their 1 bits, clear writes lower only their 1 bits, a set write without a clear register loads the whole value, and direction writes load the direction with the correct polarity. They also check that the state holds when no write occurs, that a no-output build stays quiet, and that the synchroniser has a two-cycle delay. Several behaviours can only be shown by the bench's scenarios, each on a build configured for it: the fallback of the line-level register, the byte-lane swap, the line-level read that mixes driven values with pin levels, reads and writes of unmapped offsets, and readback of the inverted direction register.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

  // Identifies which register an access targets after decode.
  typedef enum logic [2:0] {
    REG_NONE = 3'd0,
    REG_DAT  = 3'd1,
    REG_SET  = 3'd2,
    REG_CLR  = 3'd3,
    REG_DOUT = 3'd4,
    REG_DIN  = 3'd5
  } reg_id_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/gpio_lane_swap.sv
module gpio_lane_swap #(
  parameter int WIDTH = 16,
  parameter bit SWAP  = 1'b0
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int NB = WIDTH / gpio_mmio_pkg::BYTE_W;

  // Byte k of one side maps to byte NB-1-k of the other when swapping.
  for (genvar b = 0; b < NB; b++) begin : g_lane
    if (SWAP) begin : g_rev
      assign dout[b*8 +: 8] = din[(NB-1-b)*8 +: 8];
    end else begin : g_id
      assign dout[b*8 +: 8] = din[b*8 +: 8];
    end
  end
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_mmio_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter bit HAS_DAT    = 1'b1,
  parameter bit HAS_SET    = 1'b1,
  parameter bit HAS_CLR    = 1'b1,
  parameter bit HAS_DIROUT = 1'b1,
  parameter bit HAS_DIRIN  = 1'b1,
  parameter int OFF_DAT    = 0,
  parameter int OFF_SET    = 1,
  parameter int OFF_CLR    = 2,
  parameter int OFF_DIROUT = 3,
  parameter int OFF_DIRIN  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_id_e           reg_id
);
  localparam logic [ADDR_W-1:0] A_DAT  = ADDR_W'(OFF_DAT);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(OFF_DIROUT);
  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(OFF_DIRIN);

  always_comb begin
    reg_id = REG_NONE;
    if (HAS_DAT    && addr == A_DAT)  reg_id = REG_DAT;
    if (HAS_SET    && addr == A_SET)  reg_id = REG_SET;
    if (HAS_CLR    && addr == A_CLR)  reg_id = REG_CLR;
    if (HAS_DIROUT && addr == A_DOUT) reg_id = REG_DOUT;
    if (HAS_DIRIN  && addr == A_DIN)  reg_id = REG_DIN;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] pins_sync
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;
  logic [1:0]       warm_q;
  logic [1:0]       warm_d;

  always_comb begin
    warm_d = (warm_q == 2'd3) ? warm_q : warm_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      warm_q   <= '0;
    end else begin
      stage1_q <= pins;
      stage2_q <= stage1_q;
      warm_q   <= warm_d;
    end
  end

  assign pins_sync = stage2_q;

  // R3: two edges from pin to synchronised value
  assert_sync_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (pins_sync == $past(pins, 2)));
endmodule

// File: rtl/gpio_line_state.sv
module gpio_line_state
  import gpio_mmio_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter bit HAS_SET   = 1'b1,
  parameter bit HAS_CLR   = 1'b1,
  parameter bit NO_OUTPUT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_id_e          wr_id,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] oe_q
);
  logic [WIDTH-1:0] out_d;
  logic [WIDTH-1:0] oe_d;
  logic             out_en;
  logic             oe_en;
  logic             drive_ok;

  assign drive_ok = wr_en && !NO_OUTPUT;

  // Next-state for the output value and the direction.
  always_comb begin
    out_d  = out_q;
    oe_d   = oe_q;
    out_en = 1'b0;
    oe_en  = 1'b0;
    if (drive_ok) begin
      unique case (wr_id)
        REG_DAT: begin
          if (!HAS_SET) begin
            out_d  = wr_data;
            out_en = 1'b1;
          end
        end
        REG_SET: begin
          out_d  = HAS_CLR ? (out_q | wr_data) : wr_data;
          out_en = 1'b1;
        end
        REG_CLR: begin
          out_d  = out_q & ~wr_data;
          out_en = 1'b1;
        end
        REG_DOUT: begin
          oe_d  = wr_data;
          oe_en = 1'b1;
        end
        REG_DIN: begin
          oe_d  = ~wr_data;
          oe_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      if (out_en) out_q <= out_d;
      if (oe_en)  oe_q  <= oe_d;
    end
  end

  // R4: set write raises its 1 bits
  assert_set_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_ok && wr_id == REG_SET && HAS_CLR) |=>
      ((out_q & $past(wr_data)) == $past(wr_data)));
  // R4: set write leaves its 0 bits alone
  assert_set_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_ok && wr_id == REG_SET && HAS_CLR) |=>
      (((out_q ^ $past(out_q)) & ~$past(wr_data)) == '0));
  // R5: clear write lowers its 1 bits and keeps the rest
  assert_clr_lowers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_ok && wr_id == REG_CLR) |=>
      ((out_q & $past(wr_data)) == '0) &&
      (((out_q ^ $past(out_q)) & ~$past(wr_data)) == '0));
  // R6: without a clear register the set write loads everything
  assert_set_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_ok && wr_id == REG_SET && !HAS_CLR) |=> (out_q == $past(wr_data)));
  // R8: output-direction polarity
  assert_dirout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_ok && wr_id == REG_DOUT) |=> (oe_q == $past(wr_data)));
  // R9: input-direction polarity is inverted
  assert_dirin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_ok && wr_id == REG_DIN) |=> (oe_q == ~$past(wr_data)));
  // R14: no write, no change
  assert_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(out_q) && $stable(oe_q)));
  // R10: a no-output build never drives
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    NO_OUTPUT |-> (oe_q == '0 && out_q == '0));
endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl
  import gpio_mmio_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int ADDR_W     = 4,
  parameter bit HAS_DAT    = 1'b1,
  parameter bit HAS_SET    = 1'b1,
  parameter bit HAS_CLR    = 1'b1,
  parameter bit HAS_DIROUT = 1'b1,
  parameter bit HAS_DIRIN  = 1'b1,
  parameter int OFF_DAT    = 0,
  parameter int OFF_SET    = 1,
  parameter int OFF_CLR    = 2,
  parameter int OFF_DIROUT = 3,
  parameter int OFF_DIRIN  = 4,
  parameter bit NO_OUTPUT  = 1'b0,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  gpio_in,
  output logic [WIDTH-1:0]  gpio_out,
  output logic [WIDTH-1:0]  gpio_oe
);
  reg_id_e          acc_id;
  logic [WIDTH-1:0] wr_reg;
  logic [WIDTH-1:0] rd_reg;
  logic [WIDTH-1:0] rd_bus;
  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] oe_q;
  logic [WIDTH-1:0] pins_sync;
  logic             wr_en;

  gpio_addr_decode #(
    .ADDR_W(ADDR_W), .HAS_DAT(HAS_DAT), .HAS_SET(HAS_SET), .HAS_CLR(HAS_CLR),
    .HAS_DIROUT(HAS_DIROUT), .HAS_DIRIN(HAS_DIRIN), .OFF_DAT(OFF_DAT),
    .OFF_SET(OFF_SET), .OFF_CLR(OFF_CLR), .OFF_DIROUT(OFF_DIROUT),
    .OFF_DIRIN(OFF_DIRIN)
  ) u_dec (
    .addr   (bus_addr),
    .reg_id (acc_id)
  );

  gpio_lane_swap #(.WIDTH(WIDTH), .SWAP(BIG_ENDIAN)) u_wswap (
    .din  (bus_wdata),
    .dout (wr_reg)
  );

  assign wr_en = bus_sel && bus_wr && (acc_id != REG_NONE);

  gpio_line_state #(
    .WIDTH(WIDTH), .HAS_SET(HAS_SET), .HAS_CLR(HAS_CLR), .NO_OUTPUT(NO_OUTPUT)
  ) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_id   (acc_id),
    .wr_data (wr_reg),
    .out_q   (out_q),
    .oe_q    (oe_q)
  );

  gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins      (gpio_in),
    .pins_sync (pins_sync)
  );

  // Readback in register byte order.
  always_comb begin
    unique case (acc_id)
      REG_DAT:          rd_reg = (out_q & oe_q) | (pins_sync & ~oe_q);
      REG_SET, REG_CLR: rd_reg = out_q;
      REG_DOUT:         rd_reg = oe_q;
      REG_DIN:          rd_reg = ~oe_q;
      default:          rd_reg = '0;
    endcase
  end

  gpio_lane_swap #(.WIDTH(WIDTH), .SWAP(BIG_ENDIAN)) u_rswap (
    .din  (rd_reg),
    .dout (rd_bus)
  );

  assign bus_rdata = (bus_sel && !bus_wr) ? rd_bus : '0;
  assign gpio_out  = out_q;
  assign gpio_oe   = oe_q;

  initial begin
    assert_width_bytes_R11: assert (WIDTH % 8 == 0 && WIDTH > 0);
  end
endmodule

// File: tb/gpio_mmio_ctrl_test.sv
module gpio_mmio_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic [3:0]  sel;
  logic        wr;
  logic [3:0]  addr;
  logic [15:0] wdata;
  logic [15:0] in_lines;
  logic [15:0] rd_a, rd_b, rd_c, rd_d;
  logic [15:0] out_a, out_b, out_c, out_d;
  logic [15:0] oe_a, oe_b, oe_c, oe_d;
  int total = 0;
  int bad = 0;
  bit done = 0;

  // Full register set, little-endian.
  gpio_mmio_ctrl #(.WIDTH(16), .ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel[0]), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_a), .gpio_in(in_lines),
    .gpio_out(out_a), .gpio_oe(oe_a));

  // No clear, no output-direction, big-endian: dat@2 set@5 dirin@9.
  gpio_mmio_ctrl #(.WIDTH(16), .ADDR_W(4), .HAS_CLR(1'b0), .HAS_DIROUT(1'b0),
    .OFF_DAT(2), .OFF_SET(5), .OFF_DIRIN(9), .BIG_ENDIAN(1'b1)) uut_b (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel[1]), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_b), .gpio_in(in_lines),
    .gpio_out(out_b), .gpio_oe(oe_b));

  // Data plus output-direction only: dat@0 dirout@1.
  gpio_mmio_ctrl #(.WIDTH(16), .ADDR_W(4), .HAS_SET(1'b0), .HAS_CLR(1'b0),
    .HAS_DIRIN(1'b0), .OFF_DIROUT(1)) uut_c (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel[2]), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_c), .gpio_in(in_lines),
    .gpio_out(out_c), .gpio_oe(oe_c));

  // Data only at 3, cannot drive.
  gpio_mmio_ctrl #(.WIDTH(16), .ADDR_W(4), .HAS_SET(1'b0), .HAS_CLR(1'b0),
    .HAS_DIROUT(1'b0), .HAS_DIRIN(1'b0), .OFF_DAT(3), .NO_OUTPUT(1'b1)) uut_d (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel[3]), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_d), .gpio_in(in_lines),
    .gpio_out(out_d), .gpio_oe(oe_d));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called right after a falling edge; returns after the next falling edge.
  task automatic bus_write(input int u, input logic [3:0] a, input logic [15:0] d);
    sel = 4'b0;
    sel[u] = 1'b1;
    wr = 1'b1;
    addr = a;
    wdata = d;
    @(negedge clk);
    sel = 4'b0;
    wr = 1'b0;
  endtask

  // Combinational read at the current time, between edges.
  task automatic bus_read(input int u, input logic [3:0] a, output logic [15:0] v);
    sel = 4'b0;
    sel[u] = 1'b1;
    wr = 1'b0;
    addr = a;
    #1;
    case (u)
      0: v = rd_a;
      1: v = rd_b;
      2: v = rd_c;
      default: v = rd_d;
    endcase
    sel = 4'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R2 oe after reset", oe_a, 16'h0000);
    chk("R2 out after reset", out_a, 16'h0000);
    bus_read(0, 4'd3, v); chk("R2 dirout reads 0", v, 16'h0000);
    bus_read(0, 4'd4, v); chk("R2 dirin reads ones", v, 16'hFFFF);
    bus_read(1, 4'd9, v); chk("R2 dirin reads ones (swapped build)", v, 16'hFFFF);
  endtask

  task automatic t_sync();
    logic [15:0] v;
    in_lines = 16'hA5C3;
    @(negedge clk);
    bus_read(0, 4'd0, v); chk("R3 not yet after one edge", v, 16'h0000);
    @(negedge clk);
    bus_read(0, 4'd0, v); chk("R3 visible after two edges", v, 16'hA5C3);
  endtask

  task automatic t_set_clr();
    logic [15:0] v;
    bus_write(0, 4'd1, 16'h0001); chk("R1 bit 0 drives line 0", out_a, 16'h0001);
    bus_write(0, 4'd1, 16'h8100); chk("R4 set ors in bits", out_a, 16'h8101);
    bus_write(0, 4'd2, 16'h0100); chk("R5 clear lowers bit", out_a, 16'h8001);
    bus_write(0, 4'd2, 16'h0000); chk("R5 zero clear no effect", out_a, 16'h8001);
    bus_write(0, 4'd1, 16'h0000); chk("R4 zero set no effect", out_a, 16'h8001);
    bus_read(0, 4'd1, v); chk("R13 set reads value", v, 16'h8001);
    bus_read(0, 4'd2, v); chk("R13 clear reads value", v, 16'h8001);
    bus_write(0, 4'd0, 16'hFFFF); chk("R7 data write ignored with set", out_a, 16'h8001);
  endtask

  task automatic t_dir();
    logic [15:0] v;
    bus_write(0, 4'd3, 16'h00FF); chk("R8 dirout sets oe", oe_a, 16'h00FF);
    bus_read(0, 4'd4, v); chk("R9 dirin reads inverse", v, 16'hFF00);
    bus_write(0, 4'd4, 16'h0F0F); chk("R9 dirin inverse polarity", oe_a, 16'hF0F0);
    bus_read(0, 4'd3, v); chk("R9 shared state via dirout", v, 16'hF0F0);
    bus_read(0, 4'd0, v); chk("R3 mixed driven/pin read", v, 16'h8503);
    chk("R14 out held through dir writes", out_a, 16'h8001);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    bus_write(0, 4'd7, 16'hFFFF);
    chk("R12 unmapped write keeps out", out_a, 16'h8001);
    chk("R12 unmapped write keeps oe", oe_a, 16'hF0F0);
    bus_read(0, 4'd7, v); chk("R12 unmapped read 0", v, 16'h0000);
    bus_read(0, 4'd15, v); chk("R12 unmapped read 0 high", v, 16'h0000);
    bus_read(1, 4'd0, v); chk("R12 absent offset on build b", v, 16'h0000);
  endtask

  task automatic t_noclr_swap();
    logic [15:0] v;
    bus_write(1, 4'd5, 16'h1234); chk("R11 write bytes swapped", out_b, 16'h3412);
    bus_write(1, 4'd5, 16'h0000); chk("R6 set zero drives low", out_b, 16'h0000);
    bus_write(1, 4'd5, 16'h00FF); chk("R6 set loads value", out_b, 16'hFF00);
    bus_read(1, 4'd5, v); chk("R11 read bytes swapped", v, 16'h00FF);
    bus_write(1, 4'd9, 16'hFF00); chk("R9 dirin swapped inverse", oe_b, 16'hFF00);
    bus_read(1, 4'd2, v); chk("R11 data read swapped", v, 16'hC3FF);
    bus_write(1, 4'd2, 16'h0000); chk("R7 data ignored with set (b)", out_b, 16'hFF00);
  endtask

  task automatic t_data_only();
    bus_write(2, 4'd1, 16'hFFFF); chk("R8 dirout all outputs", oe_c, 16'hFFFF);
    bus_write(2, 4'd0, 16'h5A5A); chk("R7 data drives lines", out_c, 16'h5A5A);
    bus_write(2, 4'd0, 16'h0000); chk("R7 data zero drives low", out_c, 16'h0000);
  endtask

  task automatic t_no_output();
    logic [15:0] v;
    bus_write(3, 4'd3, 16'hFFFF);
    chk("R10 out stays 0", out_d, 16'h0000);
    chk("R10 oe stays 0", oe_d, 16'h0000);
    bus_read(3, 4'd3, v); chk("R10 reads pins", v, 16'hA5C3);
  endtask

  initial begin
    rst_n = 1'b0;
    sel = 4'b0;
    wr = 1'b0;
    addr = '0;
    wdata = '0;
    in_lines = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync();
    t_set_clr();
    t_dir();
    t_unmapped();
    t_noclr_swap();
    t_data_only();
    t_no_output();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule